// File: doc/BRIEF.md
# Hot-Plug Slot Sequencer

This block manages one hot-pluggable expansion slot. It watches three slow sensor inputs: the card retention latch, card presence and the operator's attention button. It also takes single-cycle power-on and power-off commands from a register interface. From these it drives the slot power enable, the card reset line, a mechanical interlock, a power indicator and an attention indicator.

Any change of power is preceded by a cancel window. The window lasts `TICK_DIV*WINDOW_TICKS` clock cycles, and the power indicator blinks throughout it. A further request inside the window abandons the change. On the way up, reset is held for `RST_HOLD` cycles after power is applied, and the slot reports ready only once the link reports up. On the way down, reset is asserted while power is still on. If the card disappears while the slot is powered, the block shuts the slot down at once.

Each recorded slot event sets a sticky status bit. Software clears a bit by writing 1 to it. The interrupt is raised for any set bit whose enable is on.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: After reset, slot_pwr, interlock, pwr_ind, slot_ready, ev_status and irq are all 0, and card_reset is 1.
- R2: A power-on request (cmd_power_on, or an attention-button press while the slot is off) is refused when latch_open=1 or card_present=0. A refusal sets status bit 3, starts no window and leaves the power indicator off.
- R3: An accepted hot-add request starts a cancel window. slot_pwr rises exactly TICK_DIV*WINDOW_TICKS cycles after the clock edge that accepted the request. During the window pwr_ind starts at 1 and toggles every TICK_DIV*BLINK_TICKS cycles.
- R4: Any request inside a window cancels it: cmd_power_on, cmd_power_off or a button press. A cancel sets status bit 4. A cancelled add returns the slot to off. A cancelled remove returns the slot to ready with power kept on.
- R5: After slot_pwr rises, card_reset stays 1 for exactly RST_HOLD cycles, then falls.
- R6: slot_ready rises, and status bit 5 is set, only when link_up is seen after reset has been released. While the slot is ready, pwr_ind is steadily 1.
- R7: interlock is 1 on every cycle that slot_pwr is 1.
- R8: From ready, cmd_power_off or a button press starts a removal window of the same length. When the window expires, card_reset is 1 for one cycle with power still on, and then slot_pwr falls.
- R9: Status bits are sticky. A bit falls only on a cycle after clr_wr=1 with the matching clr_mask bit set. A new event in that same cycle wins over the clear.
- R10: irq is 1 exactly when some status bit and the matching int_en bit are both 1.
- R11: A closing latch sets bit 0. An attention-button press sets bit 1. A falling card_present sets bit 2.
- R12: If card_present falls while the slot is powered, the block asserts card_reset and removes power without a window.
- R13: attn_ind equals attn_cmd OR status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_open | input | 1 | Retention latch sensor, 1 = open (asynchronous) |
| card_present | input | 1 | Card presence, 1 = present (asynchronous) |
| attn_button | input | 1 | Attention button level (asynchronous) |
| link_up | input | 1 | Link training finished |
| cmd_power_on | input | 1 | One-cycle hot-add command |
| cmd_power_off | input | 1 | One-cycle hot-remove command |
| attn_cmd | input | 1 | Software request for attention indicator on |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | EV_W | Write-1-to-clear mask |
| int_en | input | EV_W | Per-bit interrupt enables |
| slot_pwr | output | 1 | Slot power enable |
| card_reset | output | 1 | Card reset, 1 = asserted |
| interlock | output | 1 | Electromechanical interlock engaged |
| pwr_ind | output | 1 | Power indicator |
| attn_ind | output | 1 | Attention indicator |
| slot_ready | output | 1 | Slot powered, out of reset and linked |
| ev_status | output | EV_W | Sticky event bits |
| irq | output | 1 | Interrupt request |

## Verification
Some rules hold on every cycle, and the assertions check them continuously. Power never runs without the interlock. Power always rises into reset and always falls out of reset. Reset is held for exactly the programmed count before it is released. A ready slot is powered, out of reset and lit. A status bit never drops without a matching clear. Other behaviour only the bench scenarios can show: the exact window length, the blink phase, refusals caused by latch and presence, cancellation from both directions, the one-cycle drain on removal, the emergency shutdown on card loss, and the mapping of events to status bits.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    localparam int EV_W      = 6;
    localparam int EV_LATCH  = 0;
    localparam int EV_BUTTON = 1;
    localparam int EV_GONE   = 2;
    localparam int EV_REFUSE = 3;
    localparam int EV_CANCEL = 4;
    localparam int EV_READY  = 5;

    typedef enum logic [2:0] {
        S_OFF,
        S_ARM_ON,
        S_PWR_RST,
        S_LINK,
        S_ON,
        S_ARM_OFF,
        S_DRAIN
    } slot_state_e;

    typedef struct packed {
        logic pwr;
        logic rst;
        logic lock;
        logic ind_on;
        logic ind_blink;
        logic ready;
    } slot_drive_t;

    function automatic slot_drive_t decode_state(slot_state_e s);
        slot_drive_t d;
        d = '0;
        case (s)
            S_OFF:     begin d.rst = 1'b1; end
            S_ARM_ON:  begin d.rst = 1'b1; d.ind_blink = 1'b1; end
            S_PWR_RST: begin d.pwr = 1'b1; d.rst = 1'b1; d.lock = 1'b1; d.ind_on = 1'b1; end
            S_LINK:    begin d.pwr = 1'b1; d.lock = 1'b1; d.ind_on = 1'b1; end
            S_ON:      begin d.pwr = 1'b1; d.lock = 1'b1; d.ind_on = 1'b1; d.ready = 1'b1; end
            S_ARM_OFF: begin d.pwr = 1'b1; d.lock = 1'b1; d.ind_blink = 1'b1; end
            S_DRAIN:   begin d.pwr = 1'b1; d.rst = 1'b1; d.lock = 1'b1; d.ind_on = 1'b1; end
            default:   begin d.rst = 1'b1; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hp_window.sv
module hp_window #(
    parameter int TICK_DIV     = 10_000_000,
    parameter int WINDOW_TICKS = 50,
    parameter int BLINK_TICKS  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire,
    output logic blink
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam int WW = $clog2(WINDOW_TICKS + 1);
    localparam int BW = $clog2(BLINK_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_TICKS - 1);
    localparam logic [BW-1:0] BLK_LAST = BW'(BLINK_TICKS - 1);

    logic [PW-1:0] pre;
    logic [WW-1:0] wcnt;
    logic [BW-1:0] bcnt;
    logic          tick;

    assign tick   = run && (pre == PRE_LAST);
    assign expire = tick && (wcnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre   <= '0;
            wcnt  <= '0;
            bcnt  <= '0;
            blink <= 1'b1;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) begin
                wcnt <= wcnt + 1'b1;
                if (bcnt == BLK_LAST) begin
                    bcnt  <= '0;
                    blink <= ~blink;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hp_status.sv
module hp_status #(
    parameter int EV_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_W-1:0] set,
    input  logic            clr_wr,
    input  logic [EV_W-1:0] clr_mask,
    input  logic [EV_W-1:0] int_en,
    output logic [EV_W-1:0] status,
    output logic            irq
);
    logic [EV_W-1:0] clr_now;

    assign clr_now = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_now) | set;
        end
    end

    assign irq = |(status & int_en);
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
    import slot_hp_pkg::*;
#(
    parameter int TICK_DIV     = 10_000_000,
    parameter int WINDOW_TICKS = 50,
    parameter int BLINK_TICKS  = 5,
    parameter int RST_HOLD     = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            latch_open,
    input  logic            card_present,
    input  logic            attn_button,
    input  logic            link_up,
    input  logic            cmd_power_on,
    input  logic            cmd_power_off,
    input  logic            attn_cmd,
    input  logic            clr_wr,
    input  logic [EV_W-1:0] clr_mask,
    input  logic [EV_W-1:0] int_en,
    output logic            slot_pwr,
    output logic            card_reset,
    output logic            interlock,
    output logic            pwr_ind,
    output logic            attn_ind,
    output logic            slot_ready,
    output logic [EV_W-1:0] ev_status,
    output logic            irq
);
    localparam int RW = $clog2(RST_HOLD + 1);
    localparam logic [RW-1:0] HOLD_LAST = RW'(RST_HOLD - 1);

    slot_state_e     state, state_nx;
    slot_drive_t     drv;
    logic [2:0]      raw_in, syn, syn_q;
    logic            latch_s, pres_s, btn_s;
    logic            latch_close, press, gone;
    logic            win_run, win_expire, blink;
    logic [RW-1:0]   hold_cnt;
    logic            hold_done;
    logic [EV_W-1:0] ev_set;
    logic            ask_on, ask_any;

    assign raw_in = {attn_button, card_present, latch_open};

    hp_sync #(.W(3), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) syn_q <= '0;
        else     syn_q <= syn;
    end

    assign latch_s     = syn[0];
    assign pres_s      = syn[1];
    assign btn_s       = syn[2];
    assign latch_close = syn_q[0] & ~latch_s;
    assign gone        = syn_q[1] & ~pres_s;
    assign press       = btn_s & ~syn_q[2];

    assign win_run = (state == S_ARM_ON) || (state == S_ARM_OFF);

    hp_window #(
        .TICK_DIV     (TICK_DIV),
        .WINDOW_TICKS (WINDOW_TICKS),
        .BLINK_TICKS  (BLINK_TICKS)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .run    (win_run),
        .expire (win_expire),
        .blink  (blink)
    );

    always_ff @(posedge clk) begin
        if (rst || state != S_PWR_RST) hold_cnt <= '0;
        else                           hold_cnt <= hold_cnt + 1'b1;
    end
    assign hold_done = (hold_cnt == HOLD_LAST);

    assign ask_on  = cmd_power_on | press;
    assign ask_any = cmd_power_on | cmd_power_off | press;

    always_comb begin
        state_nx          = state;
        ev_set            = '0;
        ev_set[EV_LATCH]  = latch_close;
        ev_set[EV_BUTTON] = press;
        ev_set[EV_GONE]   = gone;
        case (state)
            S_OFF: begin
                if (ask_on) begin
                    if (latch_s || !pres_s) ev_set[EV_REFUSE] = 1'b1;
                    else                    state_nx = S_ARM_ON;
                end
            end
            S_ARM_ON: begin
                if (gone) begin
                    state_nx = S_OFF;
                end else if (ask_any) begin
                    ev_set[EV_CANCEL] = 1'b1;
                    state_nx = S_OFF;
                end else if (win_expire) begin
                    state_nx = S_PWR_RST;
                end
            end
            S_PWR_RST: begin
                if (gone)           state_nx = S_DRAIN;
                else if (hold_done) state_nx = S_LINK;
            end
            S_LINK: begin
                if (gone) begin
                    state_nx = S_DRAIN;
                end else if (link_up) begin
                    ev_set[EV_READY] = 1'b1;
                    state_nx = S_ON;
                end
            end
            S_ON: begin
                if (gone)                        state_nx = S_DRAIN;
                else if (cmd_power_off || press) state_nx = S_ARM_OFF;
            end
            S_ARM_OFF: begin
                if (gone) begin
                    state_nx = S_DRAIN;
                end else if (ask_any) begin
                    ev_set[EV_CANCEL] = 1'b1;
                    state_nx = S_ON;
                end else if (win_expire) begin
                    state_nx = S_DRAIN;
                end
            end
            S_DRAIN: state_nx = S_OFF;
            default: state_nx = S_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_OFF;
        else     state <= state_nx;
    end

    hp_status #(.EV_W(EV_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set      (ev_set),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .int_en   (int_en),
        .status   (ev_status),
        .irq      (irq)
    );

    assign drv        = decode_state(state);
    assign slot_pwr   = drv.pwr;
    assign card_reset = drv.rst;
    assign interlock  = drv.lock;
    assign slot_ready = drv.ready;
    assign pwr_ind    = drv.ind_blink ? blink : drv.ind_on;
    assign attn_ind   = attn_cmd | ev_status[EV_REFUSE];
endmodule

// File: rtl/slot_hotplug_chk.sv
module slot_hotplug_chk #(
    parameter int RST_HOLD = 1000,
    parameter int EV_W     = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            slot_pwr,
    input logic            card_reset,
    input logic            interlock,
    input logic            pwr_ind,
    input logic            slot_ready,
    input logic [EV_W-1:0] ev_status,
    input logic            clr_wr,
    input logic [EV_W-1:0] clr_mask
);
    logic        armed;
    logic [31:0] both_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            both_cnt <= '0;
        end else begin
            armed    <= 1'b1;
            both_cnt <= (slot_pwr && card_reset) ? both_cnt + 1 : '0;
        end
    end

    assert_interlock_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        slot_pwr |-> interlock);

    assert_rise_in_reset_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(slot_pwr) |-> card_reset);

    assert_hold_len_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (slot_pwr && $fell(card_reset)) |-> (both_cnt == 32'(RST_HOLD)));

    assert_reset_before_off_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(slot_pwr) |-> $past(card_reset));

    assert_ready_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        slot_ready |-> (slot_pwr && !card_reset && pwr_ind));

    generate
        for (genvar i = 0; i < EV_W; i++) begin : g_sticky
            assert_sticky_R9: assert property (@(posedge clk) disable iff (rst || !armed)
                $fell(ev_status[i]) |-> $past(clr_wr && clr_mask[i]));
        end
    endgenerate
endmodule

bind slot_hotplug_ctrl slot_hotplug_chk #(.RST_HOLD(RST_HOLD), .EV_W(slot_hp_pkg::EV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_pwr   (slot_pwr),
    .card_reset (card_reset),
    .interlock  (interlock),
    .pwr_ind    (pwr_ind),
    .slot_ready (slot_ready),
    .ev_status  (ev_status),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask)
);

// File: tb/test_slot_hotplug_ctrl.sv
module test_slot_hotplug_ctrl;
    import slot_hp_pkg::*;

    localparam int TD = 4;
    localparam int WT = 10;
    localparam int BT = 2;
    localparam int RH = 5;
    localparam int W  = TD * WT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic latch_open = 1'b1, card_present = 1'b1, attn_button = 1'b0, link_up = 1'b0;
    logic cmd_power_on = 1'b0, cmd_power_off = 1'b0, attn_cmd = 1'b0, clr_wr = 1'b0;
    logic [EV_W-1:0] clr_mask = '0, int_en = '1;
    logic slot_pwr, card_reset, interlock, pwr_ind, attn_ind, slot_ready, irq;
    logic [EV_W-1:0] ev_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    slot_hotplug_ctrl #(
        .TICK_DIV(TD), .WINDOW_TICKS(WT), .BLINK_TICKS(BT), .RST_HOLD(RH)
    ) i_slot_hotplug_ctrl (
        .clk(clk), .rst(rst), .latch_open(latch_open), .card_present(card_present),
        .attn_button(attn_button), .link_up(link_up), .cmd_power_on(cmd_power_on),
        .cmd_power_off(cmd_power_off), .attn_cmd(attn_cmd), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .int_en(int_en), .slot_pwr(slot_pwr), .card_reset(card_reset),
        .interlock(interlock), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
        .slot_ready(slot_ready), .ev_status(ev_status), .irq(irq)
    );

    function automatic logic exp_irq(logic [EV_W-1:0] ev, logic [EV_W-1:0] en);
        return |(ev & en);
    endfunction

    function automatic logic exp_blink(int c);
        return (((c - 1) / (TD * BT)) % 2) == 0;
    endfunction

    function automatic logic [EV_W-1:0] bit_of(int b);
        return EV_W'(1) << b;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_on();
        cmd_power_on = 1'b1; @(negedge clk); cmd_power_on = 1'b0;
    endtask

    task automatic pulse_off();
        cmd_power_off = 1'b1; @(negedge clk); cmd_power_off = 1'b0;
    endtask

    task automatic clear(logic [EV_W-1:0] m);
        clr_wr = 1'b1; clr_mask = m; @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic power_up_ready();
        pulse_on();
        wait_n(W + RH + 1);
        link_up = 1'b1;
        wait_n(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int bad_pwr, bad_blink, n;
        wait_n(3);
        // R1 reset state
        check("R1 slot_pwr", slot_pwr, 0);
        check("R1 card_reset", card_reset, 1);
        check("R1 indicators", {interlock, pwr_ind, slot_ready, irq}, 0);
        rst = 1'b0;
        wait_n(4);
        check("R1 status", ev_status, 0);

        // R2 refused with latch open, R13 attention follows refuse bit
        pulse_on();
        check("R2 refuse bit3", ev_status, bit_of(EV_REFUSE));
        wait_n(3);
        check("R2 no window", {slot_pwr, pwr_ind}, 0);
        check("R13 attn on refuse", attn_ind, 1);
        check("R10 irq", irq, exp_irq(ev_status, int_en));

        // R11 latch closing sets bit 0
        latch_open = 1'b0;
        wait_n(4);
        check("R11 latch bit0", ev_status, bit_of(EV_REFUSE) | bit_of(EV_LATCH));

        // R9 write-1-clear selective
        clear(bit_of(EV_REFUSE));
        check("R9 partial clear", ev_status, bit_of(EV_LATCH));
        check("R13 attn off", attn_ind, 0);
        attn_cmd = 1'b1; #1;
        check("R13 attn_cmd", attn_ind, 1);
        attn_cmd = 1'b0;
        clear('1);
        check("R9 full clear", {ev_status, irq}, 0);

        // R3 window length and blink phase
        pulse_on();
        bad_pwr = 0; bad_blink = 0;
        for (int c = 1; c <= W; c++) begin
            if (slot_pwr !== 1'b0) bad_pwr++;
            if (pwr_ind !== exp_blink(c)) bad_blink++;
            @(negedge clk);
        end
        check("R3 power held off in window", bad_pwr, 0);
        check("R3 blink phase", bad_blink, 0);
        check("R3 power on at window end", slot_pwr, 1);
        check("R7 interlock", interlock, 1);
        n = 0;
        while (slot_pwr && card_reset && n < 100) begin n++; @(negedge clk); end
        check("R5 reset hold", n, RH);
        check("R6 not ready before link", slot_ready, 0);
        link_up = 1'b1;
        wait_n(1);
        check("R6 ready", {slot_ready, pwr_ind, ev_status[EV_READY]}, 3'b111);

        // R4 cancel removal
        pulse_off();
        wait_n(10);
        pulse_off();
        check("R4 cancel keeps power", {slot_pwr, slot_ready}, 2'b11);
        check("R4 cancel bit4", ev_status[EV_CANCEL], 1);
        clear('1);

        // R8 removal with drain cycle
        pulse_off();
        bad_pwr = 0;
        for (int c = 1; c <= W; c++) begin
            if (!(slot_pwr === 1'b1 && card_reset === 1'b0)) bad_pwr++;
            @(negedge clk);
        end
        check("R8 powered during window", bad_pwr, 0);
        check("R8 drain reset with power", {slot_pwr, card_reset}, 2'b11);
        wait_n(1);
        check("R8 off after drain", {slot_pwr, card_reset, interlock}, 3'b010);
        link_up = 1'b0;

        // R4/R11 button add then button cancel
        attn_button = 1'b1; wait_n(6); attn_button = 1'b0;
        check("R11 button bit1", ev_status[EV_BUTTON], 1);
        wait_n(4);
        attn_button = 1'b1; wait_n(6); attn_button = 1'b0;
        check("R4 add cancelled", {slot_pwr, pwr_ind}, 0);
        check("R4 cancel bit4 add", ev_status[EV_CANCEL], 1);
        wait_n(W + 5);
        check("R4 stays off", slot_pwr, 0);
        clear('1);

        // R12 card removed while powered
        power_up_ready();
        check("R6 ready again", slot_ready, 1);
        card_present = 1'b0;
        wait_n(6);
        check("R12 emergency off", {slot_pwr, slot_ready}, 0);
        check("R11 gone bit2", ev_status[EV_GONE], 1);
        link_up = 1'b0;

        // R2 no card
        pulse_on();
        check("R2 refuse no card", ev_status[EV_REFUSE], 1);
        wait_n(W + 2);
        check("R2 stays off", slot_pwr, 0);
        card_present = 1'b1;
        wait_n(4);
        clear('1);

        // R10 masking
        int_en = '0;
        latch_open = 1'b1; wait_n(4);
        pulse_on();
        check("R10 masked", irq, 0);
        int_en = bit_of(EV_REFUSE); #1;
        check("R10 enabled bit", irq, 1);
        int_en = bit_of(EV_LATCH); #1;
        check("R10 other bit", irq, 0);
        clear('1);
        latch_open = 1'b0; int_en = '1;
        wait_n(4);
        clear('1);

        // constrained random
        void'($urandom(32'd1234));
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk);
            check("R10 irq random", irq, exp_irq(ev_status, int_en));
            check("R7 interlock random", (!slot_pwr) || interlock, 1);
            check("R6 ready random", (!slot_ready) || (slot_pwr && !card_reset), 1);
            check("R13 attn random", attn_ind, attn_cmd | ev_status[EV_REFUSE]);
            cmd_power_on  = ($urandom_range(0, 99) < 3);
            cmd_power_off = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 99) < 2) attn_button = ~attn_button;
            if (!interlock && $urandom_range(0, 99) < 2) latch_open = ~latch_open;
            if ($urandom_range(0, 999) < 5) card_present = ~card_present;
            link_up  = ($urandom_range(0, 99) < 30);
            attn_cmd = ($urandom_range(0, 99) < 10);
            int_en   = EV_W'($urandom);
            clr_wr   = ($urandom_range(0, 99) < 5);
            clr_mask = EV_W'($urandom);
        end
        summary();
    end
endmodule